// File: doc/BRIEF.md
# Fused Read-Modify-Write and Accumulator Execution Unit

This unit is the data path of an 8-bit NMOS-style processor core. A sequencer outside the unit fetches the opcode and the operand byte and then pulses `start`. The unit runs the ordinary accumulator arithmetic and logic operations, the shift and increment operations on memory or on A, and the plain stores and X loads. It also runs the undocumented opcodes that chain a memory modification with an accumulator operation. It returns a byte to write back with a write strobe, new A and X values, the N, Z, C and V flags, and a `done` pulse.

The opcode is split into three fields. Bits 1-0 give the group, bits 7-5 the row, and bits 4-2 the addressing column. Each row in group 11 pairs the group-10 modification of that row with the group-01 operation of that row. The modified byte goes out on the write port one cycle after `start`. The register result follows one cycle after that. In column 010, group 11 instead holds immediate-only combinations that finish in a single step. Opcodes whose results depend on analog effects are refused, as are opcodes that need state this unit does not hold. These return `unsupported` and leave every register as it was.

Top module: `fused_alu_unit`

## Requirements
- R1: While `rst` is high, and after it is released, every output is zero until the first accepted `start`.
- R2: For a group-01 opcode (bits 1-0 = 01), bits 7-5 select OR, AND, XOR or load for rows 0, 1, 2 and 5. The result goes to A, N is taken from bit 7 and Z from a zero result, and C is copied from `c_in`. `done` is high in the cycle after `start`. Whenever an operation leaves A or X unchanged, `a_out` and `x_out` return `a_in` and `x_in`.
- R3: Row 3 (add) computes A+M+C and row 7 (subtract) computes A+~M+C, both in binary. C is the carry out. V is set when both adder inputs have the same sign and the sum sign differs. Only add, subtract and the row-3 immediate combination change V; every other operation holds it. Opcode 0xEB gives the same results as 0xE9.
- R4: Row 6 of group 01 is a compare. A is unchanged, C = (A >= M), and N and Z come from A-M.
- R5: Rows 0-3 of group 10 are shift-left, rotate-left, shift-right and rotate-right. Left moves put bit 7 into C, right moves put bit 0 into C, and the rotates fill the empty bit with the old C. Column 010 works on A. The memory columns write the result with `mem_we` and leave A unchanged.
- R6: Rows 6 and 7 of group 10 decrement and increment the memory byte, set N and Z, and keep C. Row 5 loads X. Row 4 of group 01, row 4 of group 10 and row 4 of group 11 store A, X and A AND X respectively, and none of them changes a flag.
- R7: A fused opcode (group 11, column other than 010, row not 4 or 5) pulses `mem_we` with the modified byte in the cycle after `start`. A, X, the flags and `done` update one cycle later. A `start` seen during that second cycle is ignored.
- R8: In a fused opcode the accumulator step uses the modified byte. When its own carry input matters, it takes the carry left by the modification. For the logic rows, C is the modification carry. The compare row leaves A unchanged.
- R9: Column 010 of group 11 does the following: rows 0 and 1 set A = A AND M with C = bit 7; row 2 ANDs and then shifts right; row 3 ANDs and then rotates right, with C = result bit 6 and V = bit 6 XOR bit 5.
- R10: Row 6, column 010 of group 11 sets X = (A AND X) - M with no borrow-in and C as a compare. Row 5 of group 11 loads the operand into both A and X.
- R11: The following opcodes pulse `unsupported` together with `done` and make no memory write. `a_out` and `x_out` take `a_in` and `x_in`, C takes `c_in`, and N, Z and V are held. The set is: all of group 00; group 10 columns 100 and 110; group 10 column 000 except row 5; group 10 column 010 in rows 4-7; 0x9E; 0x89; 0x8B; 0x93, 0x9B and 0x9F; and 0xBB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin executing `opcode` |
| opcode | input | 8 | Instruction byte |
| operand | input | DATA_W | Immediate or memory byte |
| a_in | input | DATA_W | Current accumulator |
| x_in | input | DATA_W | Current X register |
| c_in | input | 1 | Current carry flag |
| mem_wdata | output | DATA_W | Byte to write back |
| mem_we | output | 1 | Write-back strobe |
| a_out | output | DATA_W | New accumulator |
| x_out | output | DATA_W | New X register |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |
| done | output | 1 | Operation finished |
| unsupported | output | 1 | Opcode refused |

## Verification
The bench concentrates on carry routing, because a design that feeds `c_in` rather than the modification carry into the rotate-then-add or shift-then-OR paths gives A or C off by one bit. It checks that the compare paths leave A unchanged, so a design that writes the difference into A fails. It tests overflow with equal-sign operands and checks that the flag holds across operations that do not own it. It also verifies that `done` and `mem_we` fall in separate cycles for the fused forms and that a `start` arriving during the second step is dropped. The refused opcodes are checked for a stray write or a changed register.

// File: rtl/fa_pkg.sv
package fa_pkg;
  typedef enum logic [3:0] {
    K_UNSUP, K_ALU, K_STORE, K_RMW_MEM, K_RMW_ACC, K_LOADX,
    K_LAX, K_FUSED, K_ANC, K_ALR, K_ARR, K_AXS
  } kind_e;
  typedef enum logic [1:0] {SRC_A, SRC_X, SRC_AX} src_e;
  typedef enum logic {ST_IDLE, ST_FUSE} state_e;
  localparam logic [2:0] ROW_ORA = 3'd0;
  localparam logic [2:0] ROW_AND = 3'd1;
  localparam logic [2:0] ROW_ADC = 3'd3;
  localparam logic [2:0] ROW_CMP = 3'd6;
  localparam logic [2:0] ROW_SBC = 3'd7;
endpackage

// File: rtl/fa_decode.sv
module fa_decode
  import fa_pkg::*;
(
  input  logic [7:0] op,
  output kind_e      kind,
  output src_e       st_src,
  output logic [2:0] row
);
  logic [1:0] grp;
  logic [2:0] col;
  assign grp = op[1:0];
  assign row = op[7:5];
  assign col = op[4:2];

  always_comb begin
    kind   = K_UNSUP;
    st_src = SRC_A;
    case (grp)
      2'b00: kind = K_UNSUP;
      2'b01: begin
        if (row == 3'd4) kind = (col == 3'b010) ? K_UNSUP : K_STORE;
        else             kind = K_ALU;
      end
      2'b10: begin
        st_src = SRC_X;
        if (col == 3'b100 || col == 3'b110)      kind = K_UNSUP;
        else if (col == 3'b000)                  kind = (row == 3'd5) ? K_LOADX : K_UNSUP;
        else if (col == 3'b010)                  kind = row[2] ? K_UNSUP : K_RMW_ACC;
        else if (row == 3'd4)                    kind = (col == 3'b111) ? K_UNSUP : K_STORE;
        else if (row == 3'd5)                    kind = K_LOADX;
        else                                     kind = K_RMW_MEM;
      end
      default: begin
        st_src = SRC_AX;
        if (col == 3'b010) begin
          case (row)
            3'd0, 3'd1: kind = K_ANC;
            3'd2:       kind = K_ALR;
            3'd3:       kind = K_ARR;
            3'd4:       kind = K_UNSUP;
            3'd5:       kind = K_LAX;
            3'd6:       kind = K_AXS;
            default:    kind = K_ALU;
          endcase
        end else if (row == 3'd4) begin
          kind = (col == 3'b100 || col == 3'b110 || col == 3'b111) ? K_UNSUP : K_STORE;
        end else if (row == 3'd5) begin
          kind = (col == 3'b110) ? K_UNSUP : K_LAX;
        end else begin
          kind = K_FUSED;
        end
      end
    endcase
  end
endmodule

// File: rtl/fa_rmw.sv
module fa_rmw #(
  parameter int DATA_W = 8
) (
  input  logic [2:0]        row,
  input  logic [DATA_W-1:0] din,
  input  logic              cin,
  output logic [DATA_W-1:0] dout,
  output logic              cout
);
  localparam int MSB = DATA_W - 1;
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  always_comb begin
    dout = din;
    cout = cin;
    case (row)
      3'd0: begin dout = {din[MSB-1:0], 1'b0}; cout = din[MSB]; end
      3'd1: begin dout = {din[MSB-1:0], cin};  cout = din[MSB]; end
      3'd2: begin dout = {1'b0, din[MSB:1]};   cout = din[0];   end
      3'd3: begin dout = {cin, din[MSB:1]};    cout = din[0];   end
      3'd6: dout = din - ONE;
      3'd7: dout = din + ONE;
      default: ;
    endcase
  end
endmodule

// File: rtl/fa_alu.sv
module fa_alu #(
  parameter int DATA_W = 8
) (
  input  logic [2:0]        row,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] m,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cout,
  output logic              vout
);
  localparam int MSB = DATA_W - 1;
  logic              subtract;
  logic [DATA_W-1:0] addend;
  logic              carry_add;
  logic [DATA_W:0]   sum;

  assign subtract  = (row == 3'd6) || (row == 3'd7);
  assign addend    = subtract ? ~m : m;
  assign carry_add = (row == 3'd6) ? 1'b1 : cin;
  assign sum       = {1'b0, a} + {1'b0, addend} + {{DATA_W{1'b0}}, carry_add};
  assign vout      = (a[MSB] == addend[MSB]) && (sum[MSB] != a[MSB]);

  always_comb begin
    res  = a;
    cout = cin;
    case (row)
      3'd0: res = a | m;
      3'd1: res = a & m;
      3'd2: res = a ^ m;
      3'd5: res = m;
      3'd3, 3'd6, 3'd7: begin res = sum[MSB:0]; cout = sum[DATA_W]; end
      default: ;
    endcase
  end
endmodule

// File: rtl/fused_alu_unit.sv
module fused_alu_unit
  import fa_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [7:0]        opcode,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] x_in,
  input  logic              c_in,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic [DATA_W-1:0] a_out,
  output logic [DATA_W-1:0] x_out,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_c,
  output logic              flag_v,
  output logic              done,
  output logic              unsupported
);
  localparam int MSB = DATA_W - 1;

  kind_e             kind;
  src_e              st_src;
  logic [2:0]        row;
  state_e            state;
  logic [2:0]        row_q;
  logic [DATA_W-1:0] a_q, x_q, memv_q;
  logic              cq;

  logic [2:0]        rmw_row, alu_row;
  logic [DATA_W-1:0] rmw_din, rmw_res, alu_a, alu_m, alu_res, st_val;
  logic              rmw_c, alu_cin, alu_c, alu_v;

  fa_decode u_dec (.op(opcode), .kind(kind), .st_src(st_src), .row(row));

  // Shifter input: A for the accumulator forms, A AND M for the combined immediates
  always_comb begin
    rmw_row = row;
    rmw_din = operand;
    if (kind == K_ALR) rmw_row = 3'd2;
    if (kind == K_ARR) rmw_row = 3'd3;
    if (kind == K_RMW_ACC) rmw_din = a_in;
    else if (kind == K_ALR || kind == K_ARR) rmw_din = a_in & operand;
  end

  fa_rmw #(.DATA_W(DATA_W)) u_rmw (
    .row(rmw_row), .din(rmw_din), .cin(c_in), .dout(rmw_res), .cout(rmw_c));

  // Adder input: captured operands during the second step of a fused opcode
  always_comb begin
    if (state == ST_FUSE) begin
      alu_row = row_q;
      alu_a   = a_q;
      alu_m   = memv_q;
      alu_cin = cq;
    end else begin
      alu_row = (kind == K_ANC) ? ROW_AND : (kind == K_AXS) ? ROW_CMP : row;
      alu_a   = (kind == K_AXS) ? (a_in & x_in) : a_in;
      alu_m   = operand;
      alu_cin = c_in;
    end
  end

  fa_alu #(.DATA_W(DATA_W)) u_alu (
    .row(alu_row), .a(alu_a), .m(alu_m), .cin(alu_cin),
    .res(alu_res), .cout(alu_c), .vout(alu_v));

  always_comb begin
    case (st_src)
      SRC_X:   st_val = x_in;
      SRC_AX:  st_val = a_in & x_in;
      default: st_val = a_in;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      mem_wdata   <= '0;
      mem_we      <= 1'b0;
      a_out       <= '0;
      x_out       <= '0;
      flag_n      <= 1'b0;
      flag_z      <= 1'b0;
      flag_c      <= 1'b0;
      flag_v      <= 1'b0;
      done        <= 1'b0;
      unsupported <= 1'b0;
      row_q       <= '0;
      a_q         <= '0;
      x_q         <= '0;
      memv_q      <= '0;
      cq          <= 1'b0;
    end else begin
      done        <= 1'b0;
      mem_we      <= 1'b0;
      unsupported <= 1'b0;
      if (state == ST_FUSE) begin
        a_out  <= (row_q == ROW_CMP) ? a_q : alu_res;
        x_out  <= x_q;
        flag_n <= alu_res[MSB];
        flag_z <= (alu_res == '0);
        flag_c <= alu_c;
        if (row_q == ROW_ADC || row_q == ROW_SBC) flag_v <= alu_v;
        done   <= 1'b1;
        state  <= ST_IDLE;
      end else if (start) begin
        a_out  <= a_in;
        x_out  <= x_in;
        flag_c <= c_in;
        done   <= (kind != K_FUSED);
        case (kind)
          K_UNSUP: unsupported <= 1'b1;
          K_ALU: begin
            if (row != ROW_CMP) a_out <= alu_res;
            flag_n <= alu_res[MSB];
            flag_z <= (alu_res == '0);
            flag_c <= alu_c;
            if (row == ROW_ADC || row == ROW_SBC) flag_v <= alu_v;
          end
          K_STORE: begin
            mem_wdata <= st_val;
            mem_we    <= 1'b1;
          end
          K_RMW_MEM: begin
            mem_wdata <= rmw_res;
            mem_we    <= 1'b1;
            flag_n    <= rmw_res[MSB];
            flag_z    <= (rmw_res == '0);
            flag_c    <= rmw_c;
          end
          K_RMW_ACC, K_ALR: begin
            a_out  <= rmw_res;
            flag_n <= rmw_res[MSB];
            flag_z <= (rmw_res == '0);
            flag_c <= rmw_c;
          end
          K_ARR: begin
            a_out  <= rmw_res;
            flag_n <= rmw_res[MSB];
            flag_z <= (rmw_res == '0);
            flag_c <= rmw_res[MSB-1];
            flag_v <= rmw_res[MSB-1] ^ rmw_res[MSB-2];
          end
          K_LOADX, K_LAX: begin
            x_out  <= operand;
            if (kind == K_LAX) a_out <= operand;
            flag_n <= operand[MSB];
            flag_z <= (operand == '0);
          end
          K_ANC: begin
            a_out  <= alu_res;
            flag_n <= alu_res[MSB];
            flag_z <= (alu_res == '0);
            flag_c <= alu_res[MSB];
          end
          K_AXS: begin
            x_out  <= alu_res;
            flag_n <= alu_res[MSB];
            flag_z <= (alu_res == '0);
            flag_c <= alu_c;
          end
          K_FUSED: begin
            mem_wdata <= rmw_res;
            mem_we    <= 1'b1;
            row_q     <= row;
            a_q       <= a_in;
            x_q       <= x_in;
            memv_q    <= rmw_res;
            cq        <= rmw_c;
            state     <= ST_FUSE;
          end
          default: ;
        endcase
      end
    end
  end

  AST_SINGLE_DONE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && start && kind != K_FUSED) |=> done && state == ST_IDLE); // R2
  AST_FUSE_WRITE_FIRST: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && start && kind == K_FUSED) |=> mem_we && !done); // R7
  AST_FUSE_FINISH: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FUSE) |=> done && !mem_we && state == ST_IDLE); // R7
  AST_COMPARE_KEEPS_A: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FUSE && row_q == ROW_CMP) |=> a_out == $past(a_q)); // R8
  AST_UNSUP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    unsupported |-> done && !mem_we); // R11
  AST_UNSUP_REGS_KEPT: assert property (@(posedge clk) disable iff (rst)
    unsupported |-> a_out == $past(a_in) && x_out == $past(x_in) && $stable(flag_v)); // R11
endmodule

// File: tb/fused_alu_unit_test.sv
`timescale 1ns/1ps
module fused_alu_unit_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [7:0] opcode = 8'h00, operand = 8'h00, a_in = 8'h00, x_in = 8'h00;
  logic       c_in = 1'b0;
  logic [7:0] mem_wdata, a_out, x_out;
  logic       mem_we, flag_n, flag_z, flag_c, flag_v, done, unsupported;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  fused_alu_unit uut (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode), .operand(operand),
    .a_in(a_in), .x_in(x_in), .c_in(c_in), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .a_out(a_out), .x_out(x_out), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c),
    .flag_v(flag_v), .done(done), .unsupported(unsupported));

  typedef struct packed {
    logic [7:0] op, m, a, x;
    logic       c, fu, we;
    logic [7:0] wd, ea, ex;
    logic       en, ez, ec, eu;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 40;
  localparam vec_t VEC [NV] = '{
    // R2 logic and load
    {8'h09,8'h0F,8'hF0,8'h11,1'b0,1'b0,1'b0,8'h00,8'hFF,8'h11,1'b1,1'b0,1'b0,1'b0,4'd2},
    {8'h29,8'h0F,8'hF0,8'h11,1'b1,1'b0,1'b0,8'h00,8'h00,8'h11,1'b0,1'b1,1'b1,1'b0,4'd2},
    {8'h49,8'hFF,8'h0F,8'h11,1'b0,1'b0,1'b0,8'h00,8'hF0,8'h11,1'b1,1'b0,1'b0,1'b0,4'd2},
    {8'hA9,8'h80,8'h00,8'h11,1'b0,1'b0,1'b0,8'h00,8'h80,8'h11,1'b1,1'b0,1'b0,1'b0,4'd2},
    // R3 add and subtract
    {8'h69,8'h50,8'h50,8'h11,1'b0,1'b0,1'b0,8'h00,8'hA0,8'h11,1'b1,1'b0,1'b0,1'b0,4'd3},
    {8'h69,8'h01,8'hFF,8'h11,1'b1,1'b0,1'b0,8'h00,8'h01,8'h11,1'b0,1'b0,1'b1,1'b0,4'd3},
    {8'hE9,8'h03,8'h05,8'h11,1'b1,1'b0,1'b0,8'h00,8'h02,8'h11,1'b0,1'b0,1'b1,1'b0,4'd3},
    {8'hEB,8'h05,8'h03,8'h11,1'b1,1'b0,1'b0,8'h00,8'hFE,8'h11,1'b1,1'b0,1'b0,1'b0,4'd3},
    // R4 compare
    {8'hC9,8'h40,8'h40,8'h11,1'b0,1'b0,1'b0,8'h00,8'h40,8'h11,1'b0,1'b1,1'b1,1'b0,4'd4},
    {8'hC9,8'h20,8'h10,8'h11,1'b0,1'b0,1'b0,8'h00,8'h10,8'h11,1'b1,1'b0,1'b0,1'b0,4'd4},
    // R5 shifts and rotates
    {8'h0A,8'h00,8'h81,8'h11,1'b0,1'b0,1'b0,8'h00,8'h02,8'h11,1'b0,1'b0,1'b1,1'b0,4'd5},
    {8'h6A,8'h00,8'h01,8'h11,1'b1,1'b0,1'b0,8'h00,8'h80,8'h11,1'b1,1'b0,1'b1,1'b0,4'd5},
    {8'h06,8'hC0,8'h12,8'h11,1'b0,1'b0,1'b1,8'h80,8'h12,8'h11,1'b1,1'b0,1'b1,1'b0,4'd5},
    {8'h26,8'h80,8'h12,8'h11,1'b0,1'b0,1'b1,8'h00,8'h12,8'h11,1'b0,1'b1,1'b1,1'b0,4'd5},
    {8'h46,8'h03,8'h12,8'h11,1'b1,1'b0,1'b1,8'h01,8'h12,8'h11,1'b0,1'b0,1'b1,1'b0,4'd5},
    {8'h66,8'h02,8'h12,8'h11,1'b1,1'b0,1'b1,8'h81,8'h12,8'h11,1'b1,1'b0,1'b0,1'b0,4'd5},
    // R6 step, load X, stores
    {8'hC6,8'h00,8'h12,8'h11,1'b1,1'b0,1'b1,8'hFF,8'h12,8'h11,1'b1,1'b0,1'b1,1'b0,4'd6},
    {8'hE6,8'hFF,8'h12,8'h11,1'b0,1'b0,1'b1,8'h00,8'h12,8'h11,1'b0,1'b1,1'b0,1'b0,4'd6},
    {8'hA6,8'h00,8'h12,8'h55,1'b1,1'b0,1'b0,8'h00,8'h12,8'h00,1'b0,1'b1,1'b1,1'b0,4'd6},
    {8'h8D,8'h00,8'h3C,8'h11,1'b0,1'b0,1'b1,8'h3C,8'h3C,8'h11,1'b0,1'b1,1'b0,1'b0,4'd6},
    {8'h86,8'h00,8'h3C,8'hA5,1'b0,1'b0,1'b1,8'hA5,8'h3C,8'hA5,1'b0,1'b1,1'b0,1'b0,4'd6},
    {8'h87,8'h00,8'hF0,8'h3C,1'b1,1'b0,1'b1,8'h30,8'hF0,8'h3C,1'b0,1'b1,1'b1,1'b0,4'd6},
    // R8 fused forms
    {8'h07,8'h81,8'h10,8'h11,1'b0,1'b1,1'b1,8'h02,8'h12,8'h11,1'b0,1'b0,1'b1,1'b0,4'd8},
    {8'h27,8'h80,8'hFF,8'h11,1'b1,1'b1,1'b1,8'h01,8'h01,8'h11,1'b0,1'b0,1'b1,1'b0,4'd8},
    {8'h47,8'h03,8'h01,8'h11,1'b0,1'b1,1'b1,8'h01,8'h00,8'h11,1'b0,1'b1,1'b1,1'b0,4'd8},
    {8'h67,8'h01,8'h10,8'h11,1'b0,1'b1,1'b1,8'h00,8'h11,8'h11,1'b0,1'b0,1'b0,1'b0,4'd8},
    {8'hC7,8'h06,8'h05,8'h11,1'b0,1'b1,1'b1,8'h05,8'h05,8'h11,1'b0,1'b1,1'b1,1'b0,4'd8},
    {8'hE7,8'h04,8'h0A,8'h11,1'b1,1'b1,1'b1,8'h05,8'h05,8'h11,1'b0,1'b0,1'b1,1'b0,4'd8},
    // R9 immediate combinations
    {8'h0B,8'hF0,8'h8F,8'h11,1'b0,1'b0,1'b0,8'h00,8'h80,8'h11,1'b1,1'b0,1'b1,1'b0,4'd9},
    {8'h2B,8'h0F,8'h8F,8'h11,1'b1,1'b0,1'b0,8'h00,8'h0F,8'h11,1'b0,1'b0,1'b0,1'b0,4'd9},
    {8'h4B,8'hFF,8'h03,8'h11,1'b0,1'b0,1'b0,8'h00,8'h01,8'h11,1'b0,1'b0,1'b1,1'b0,4'd9},
    {8'h6B,8'hFF,8'hC0,8'h11,1'b1,1'b0,1'b0,8'h00,8'hE0,8'h11,1'b1,1'b0,1'b1,1'b0,4'd9},
    // R10 masked subtract into X, dual load
    {8'hCB,8'h10,8'hF0,8'h3F,1'b0,1'b0,1'b0,8'h00,8'hF0,8'h20,1'b0,1'b0,1'b1,1'b0,4'd10},
    {8'hCB,8'h10,8'h0F,8'h0F,1'b1,1'b0,1'b0,8'h00,8'h0F,8'hFF,1'b1,1'b0,1'b0,1'b0,4'd10},
    {8'hAB,8'h7E,8'h12,8'h11,1'b0,1'b0,1'b0,8'h00,8'h7E,8'h7E,1'b0,1'b0,1'b0,1'b0,4'd10},
    {8'hA7,8'h00,8'h12,8'h11,1'b1,1'b0,1'b0,8'h00,8'h00,8'h00,1'b0,1'b1,1'b1,1'b0,4'd10},
    // R11 refused opcodes
    {8'h8B,8'hFF,8'h12,8'h34,1'b1,1'b0,1'b0,8'h00,8'h12,8'h34,1'b0,1'b1,1'b1,1'b1,4'd11},
    {8'h9B,8'hFF,8'hAA,8'hBB,1'b0,1'b0,1'b0,8'h00,8'hAA,8'hBB,1'b0,1'b1,1'b0,1'b1,4'd11},
    {8'h02,8'hFF,8'h01,8'h02,1'b1,1'b0,1'b0,8'h00,8'h01,8'h02,1'b0,1'b1,1'b1,1'b1,4'd11},
    {8'h00,8'hFF,8'h01,8'h02,1'b0,1'b0,1'b0,8'h00,8'h01,8'h02,1'b0,1'b1,1'b0,1'b1,4'd11}
  };

  task automatic chk(input string what, input int rq, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %02h expected %02h", rq, what, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] op, input logic [7:0] m, input logic [7:0] a,
                       input logic [7:0] x, input logic c);
    @(negedge clk);
    opcode = op; operand = m; a_in = a; x_in = x; c_in = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("reset a_out", 1, a_out, 8'h00);
    chk("reset x_out", 1, x_out, 8'h00);
    chk("reset flags", 1, {4'h0, flag_n, flag_z, flag_c, flag_v}, 8'h00);
    chk("reset strobes", 1, {5'h0, mem_we, done, unsupported}, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    chk("after reset strobes", 1, {5'h0, mem_we, done, unsupported}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VEC[i];
      issue(v.op, v.m, v.a, v.x, v.c);
      if (v.fu) begin
        // R7 write in first cycle, registers one cycle later
        chk("fused step1 mem_we", 7, {7'h0, mem_we}, 8'h01);
        chk("fused step1 done", 7, {7'h0, done}, 8'h00);
        chk("fused step1 wdata", int'(v.rq), mem_wdata, v.wd);
        @(negedge clk);
        chk("fused step2 mem_we", 7, {7'h0, mem_we}, 8'h00);
      end else begin
        chk("mem_we", int'(v.rq), {7'h0, mem_we}, {7'h0, v.we});
        if (v.we) chk("mem_wdata", int'(v.rq), mem_wdata, v.wd);
      end
      chk("done", int'(v.rq), {7'h0, done}, 8'h01);
      chk("unsupported", int'(v.rq), {7'h0, unsupported}, {7'h0, v.eu});
      chk("a_out", int'(v.rq), a_out, v.ea);
      chk("x_out", int'(v.rq), x_out, v.ex);
      chk("NZC", int'(v.rq), {5'h0, flag_n, flag_z, flag_c}, {5'h0, v.en, v.ez, v.ec});
    end

    // R3 overflow: equal signs, sum sign flips
    issue(8'h69, 8'h50, 8'h50, 8'h00, 1'b0);
    chk("ADC V set", 3, {7'h0, flag_v}, 8'h01);
    issue(8'hC9, 8'h7F, 8'h01, 8'h00, 1'b0);
    chk("CMP holds V", 3, {7'h0, flag_v}, 8'h01);
    issue(8'h69, 8'h01, 8'h01, 8'h00, 1'b0);
    chk("ADC V clear", 3, {7'h0, flag_v}, 8'h00);
    issue(8'hE9, 8'h01, 8'h80, 8'h00, 1'b1);
    chk("SBC 0xE9 result", 3, a_out, 8'h7F);
    chk("SBC 0xE9 V", 3, {7'h0, flag_v}, 8'h01);
    issue(8'h69, 8'h01, 8'h01, 8'h00, 1'b0);
    issue(8'hEB, 8'h01, 8'h80, 8'h00, 1'b1);
    chk("SBC 0xEB result", 3, a_out, 8'h7F);
    chk("SBC 0xEB V", 3, {7'h0, flag_v}, 8'h01);
    chk("SBC 0xEB C", 3, {7'h0, flag_c}, 8'h01);

    // R9 combined AND-rotate overflow from bits 6 and 5
    issue(8'h6B, 8'hFF, 8'h40, 8'h00, 1'b0);
    chk("ARR result", 9, a_out, 8'h20);
    chk("ARR V", 9, {7'h0, flag_v}, 8'h01);
    chk("ARR C", 9, {7'h0, flag_c}, 8'h00);

    // R7 start held during second step is dropped
    @(negedge clk);
    opcode = 8'h07; operand = 8'h81; a_in = 8'h10; x_in = 8'h11; c_in = 1'b0; start = 1'b1;
    @(negedge clk);
    opcode = 8'h09; operand = 8'hFF; a_in = 8'h00;
    chk("busy step1 mem_we", 7, {7'h0, mem_we}, 8'h01);
    @(negedge clk);
    start = 1'b0;
    chk("busy step2 a_out", 7, a_out, 8'h12);
    chk("busy step2 done", 7, {7'h0, done}, 8'h01);
    @(negedge clk);
    chk("dropped start done", 7, {7'h0, done}, 8'h00);
    chk("dropped start a_out", 7, a_out, 8'h12);

    // R11 more refused opcodes keep registers and write nothing
    issue(8'h9E, 8'h00, 8'h5A, 8'hA5, 1'b1);
    chk("SHX refused", 11, {6'h0, unsupported, mem_we}, 8'h02);
    chk("SHX a_out", 11, a_out, 8'h5A);
    issue(8'h89, 8'h00, 8'h33, 8'h44, 1'b0);
    chk("0x89 refused", 11, {6'h0, unsupported, mem_we}, 8'h02);
    chk("0x89 x_out", 11, x_out, 8'h44);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule